// File: doc/BRIEF.md
# I2C-Programmable Configuration Switch

This block takes the place of a bank of DIP switches or jumpers. A small setting register can be written and read over an I2C bus. Its value is retained across power cycles, and reset models that retention by loading a parameterised value that stands for the last stored setting.

Five of the six setting bits feed one side of a 2-to-1 multiplexer. The other side of the multiplexer is five live external pins, and a routing input picks which side drives the five multiplexed outputs. The sixth setting bit drives a dedicated output directly.

An active-low force input pulls every output low. A lock input freezes the setting register while the bus transfer itself goes on as normal. All outputs, and the bus data line, are open-drain and are represented as pull-low enables. The bus lines are oversampled by the block clock.

Top module: `cfg_switch_i2c`

## Requirements
- R1: After reset the setting register holds the parameter `SET_INIT` (default 6'h2A), and a bus read returns that value.
- R2: The 7-bit target address is `ADDR_PREFIX` (default 5'b10011) followed by `addr_sel_i[1]` and then `addr_sel_i[0]`. A matching address byte is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the block ignores the bytes that follow.
- R3: A write (address byte bit 0 = 0) followed by one data byte loads bits 5:0 of that byte into the setting register and acknowledges the byte. Bits 7:6 are discarded.
- R4: A read (address byte bit 0 = 1) returns the register in bits 5:0, with bits 7:6 as 0, most significant bit first. While the controller acknowledges, the same value is sent again.
- R5: While `lock_i` is 1, data bytes are still acknowledged, but the setting register does not change.
- R6: With `route_reg_i` = 0, output bits 4:0 follow `ext_in_i[4:0]`. With `route_reg_i` = 1, they follow setting bits 4:0, bit for bit.
- R7: Output bit 5 always follows setting bit 5, whatever the value of `route_reg_i`.
- R8: While `force_low_n_i` is 0, all six outputs are driven low (`out_pull_o` = 6'b111111), whatever the routing and the register.
- R9: Open-drain encoding: `out_pull_o[i]` = 1 pulls output i low (logic 0), and 0 releases it (logic 1). `sda_pull_o` = 1 pulls SDA low.
- R10: Several data bytes in one write transfer each overwrite the register, so the last byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; loads the retained setting |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pulls the bus data line low when 1 |
| addr_sel_i | input | 2 | Low two bits of the target address |
| ext_in_i | input | 5 | External inputs to the multiplexer |
| route_reg_i | input | 1 | 0 routes the pins, 1 routes the register |
| force_low_n_i | input | 1 | Active-low force of all outputs to 0 |
| lock_i | input | 1 | Write protect for the setting register |
| out_pull_o | output | 6 | Pull-low enables of the six outputs |

## Verification
On every cycle, the assertions check the output path: the force-low rule, the two routing choices, the direct path for bit 5, and the freeze of the register while locked. They also check that SDA is only pulled during a transfer. Only the bench's bus scenarios can show the address match and mismatch, the bit ordering of reads, the discarding of the upper data bits, and multi-byte overwrites. Those behaviours depend on whole sequences of bus edges.

// File: rtl/cfg_switch_i2c.sv
module cfg_switch_i2c #(
  parameter int             MUX_W       = 5,
  parameter logic [4:0]     ADDR_PREFIX = 5'b10011,
  parameter logic [MUX_W:0] SET_INIT    = 'h2A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [1:0]       addr_sel_i,
  input  logic [MUX_W-1:0] ext_in_i,
  input  logic             route_reg_i,
  input  logic             force_low_n_i,
  input  logic             lock_i,
  output logic [MUX_W:0]   out_pull_o
);
  localparam int SET_W = MUX_W + 1;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WDATA, WACK, RDATA, RACK} st_t;

  st_t              st;
  logic [2:0]       scl_sr, sda_sr;
  logic [3:0]       cnt;
  logic [7:0]       sh;
  logic             rw;
  logic [SET_W-1:0] set_q;
  logic [7:0]       rd_byte;
  logic [MUX_W-1:0] sel_val;
  logic             busy;

  wire scl_rise = scl_sr[1] & ~scl_sr[2];
  wire scl_fall = ~scl_sr[1] & scl_sr[2];
  wire start_c  = scl_sr[1] & scl_sr[2] & sda_sr[2] & ~sda_sr[1];
  wire stop_c   = scl_sr[1] & scl_sr[2] & ~sda_sr[2] & sda_sr[1];

  assign rd_byte    = 8'(set_q);
  assign sel_val    = route_reg_i ? set_q[MUX_W-1:0] : ext_in_i;
  assign out_pull_o = force_low_n_i ? ~{set_q[MUX_W], sel_val} : '1;
  assign busy       = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      sh         <= '0;
      rw         <= 1'b0;
      sda_pull_o <= 1'b0;
      set_q      <= SET_INIT;
    end else if (start_c) begin
      st         <= ADDR;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      st         <= IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (st)
        ADDR, WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_sr[1]};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == ADDR) begin
              if (sh[7:1] == {ADDR_PREFIX, addr_sel_i}) begin
                st         <= AACK;
                rw         <= sh[0];
                sda_pull_o <= 1'b1;
              end else begin
                st <= IDLE;
              end
            end else begin
              st         <= WACK;
              sda_pull_o <= 1'b1;
              if (!lock_i) set_q <= sh[SET_W-1:0];
            end
          end
        end
        AACK: begin
          if (scl_fall) begin
            if (rw) begin
              st         <= RDATA;
              sda_pull_o <= ~rd_byte[7];
              sh         <= {rd_byte[6:0], 1'b0};
              cnt        <= 4'd1;
            end else begin
              st         <= WDATA;
              sda_pull_o <= 1'b0;
              cnt        <= '0;
            end
          end
        end
        WACK: begin
          if (scl_fall) begin
            st         <= WDATA;
            sda_pull_o <= 1'b0;
            cnt        <= '0;
          end
        end
        RDATA: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              st         <= RACK;
              sda_pull_o <= 1'b0;
            end else begin
              sda_pull_o <= ~sh[7];
              sh         <= {sh[6:0], 1'b0};
              cnt        <= cnt + 4'd1;
            end
          end
        end
        RACK: begin
          if (scl_rise) begin
            sh[0] <= sda_sr[1];
          end else if (scl_fall) begin
            if (sh[0]) begin
              st <= IDLE;
            end else begin
              st         <= RDATA;
              sda_pull_o <= ~rd_byte[7];
              sh         <= {rd_byte[6:0], 1'b0};
              cnt        <= 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_switch_i2c_chk.sv
module cfg_switch_i2c_chk #(
  parameter int MUX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             force_low_n_i,
  input logic             route_reg_i,
  input logic             lock_i,
  input logic [MUX_W-1:0] ext_in_i,
  input logic [MUX_W:0]   set_q,
  input logic [MUX_W:0]   out_pull_o,
  input logic             sda_pull_o,
  input logic             busy
);
  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !force_low_n_i |-> out_pull_o == '1);

  assert_route_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_low_n_i && !route_reg_i) |-> out_pull_o[MUX_W-1:0] == ~ext_in_i);

  assert_route_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_low_n_i && route_reg_i) |-> out_pull_o[MUX_W-1:0] == ~set_q[MUX_W-1:0]);

  assert_direct_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_low_n_i |-> out_pull_o[MUX_W] == ~set_q[MUX_W]);

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_i) |-> $stable(set_q));

  assert_sda_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> busy);
endmodule

bind cfg_switch_i2c cfg_switch_i2c_chk #(.MUX_W(MUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_low_n_i(force_low_n_i),
  .route_reg_i(route_reg_i), .lock_i(lock_i), .ext_in_i(ext_in_i),
  .set_q(set_q), .out_pull_o(out_pull_o), .sda_pull_o(sda_pull_o), .busy(busy)
);

// File: tb/cfg_switch_i2c_tb_top.sv
module cfg_switch_i2c_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'b1001110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [1:0] asel = 2'b10;
  logic [4:0] ext = '0;
  logic route = 1'b0, frc_n = 1'b1, lock = 1'b0;
  logic [5:0] opull;
  wire sda_bus = sda_m & ~sda_pull;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfg_switch_i2c dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .addr_sel_i(asel), .ext_in_i(ext), .route_reg_i(route), .force_low_n_i(frc_n),
    .lock_i(lock), .out_pull_o(opull)
  );

  // force_n, route, ext, expected pull (register = 6'h2A)
  localparam logic [12:0] VEC [7] = '{
    {1'b1, 1'b0, 5'b10011, 6'b001100},
    {1'b1, 1'b0, 5'b00000, 6'b011111},
    {1'b1, 1'b0, 5'b11111, 6'b000000},
    {1'b1, 1'b1, 5'b10011, 6'b010101},
    {1'b1, 1'b1, 5'b11111, 6'b010101},
    {1'b0, 1'b1, 5'b10011, 6'b111111},
    {1'b0, 1'b0, 5'b00000, 6'b111111}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_m = b; qw(); scl = 1'b1; qw(); r = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, r); d[i] = r; end
    bit_xfer(last, r);
  endtask

  task automatic reg_read(output logic [7:0] d, output logic ack);
    i2c_start(); wr_byte({DEV, 1'b1}, ack);
    if (ack) rd_byte(1'b1, d); else d = 8'hEE;
    i2c_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d, d2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset value visible through outputs (route register)
    route = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", opull, 6'b010101);

    // R6 R7 R8 R9 output path vectors
    for (int v = 0; v < 7; v++) begin
      frc_n = VEC[v][12]; route = VEC[v][11]; ext = VEC[v][10:6];
      @(negedge clk);
      chk($sformatf("R6/R7/R8/R9 vector %0d", v), opull, VEC[v][5:0]);
    end
    frc_n = 1'b1; route = 1'b1;

    // R1 R4 read back reset value
    reg_read(d, ack);
    chk("R2 read address ack", ack, 1);
    chk("R1 R4 read reset value", d, 8'h2A);

    // R3 write then read
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h15, ack2); i2c_stop();
    chk("R2 write address ack", ack, 1);
    chk("R3 data ack", ack2, 1);
    reg_read(d, ack);
    chk("R3 readback", d, 8'h15);
    @(negedge clk);
    chk("R6 register routed after write", opull, 6'b101010);

    // R3 upper bits discarded, R4 upper bits read 0
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'hFF, ack2); i2c_stop();
    reg_read(d, ack);
    chk("R3 R4 upper bits dropped", d, 8'h3F);

    // R2 wrong address: no ack, register untouched
    i2c_start(); wr_byte({7'b1001111, 1'b0}, ack); wr_byte(8'h00, ack2); i2c_stop();
    chk("R2 mismatch nack", ack, 0);
    reg_read(d, ack);
    chk("R2 mismatch no write", d, 8'h3F);

    // R2 address pins change the address
    asel = 2'b01;
    reg_read(d, ack);
    chk("R2 old address nack after pin change", ack, 0);
    i2c_start(); wr_byte({7'b1001101, 1'b1}, ack); rd_byte(1'b1, d); i2c_stop();
    chk("R2 new address ack", ack, 1);
    chk("R2 new address data", d, 8'h3F);
    asel = 2'b10;

    // R5 lock: acked, not stored
    lock = 1'b1;
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h00, ack2); i2c_stop();
    chk("R5 locked data ack", ack2, 1);
    lock = 1'b0;
    reg_read(d, ack);
    chk("R5 locked register kept", d, 8'h3F);

    // R10 multi-byte write: last wins
    i2c_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(8'h01, ack2); wr_byte(8'h27, ack2); i2c_stop();
    chk("R10 second byte ack", ack2, 1);
    @(negedge clk);
    chk("R10 R7 outputs after multi write", opull, 6'b011000);

    // R4 two-byte read with controller ack
    i2c_start(); wr_byte({DEV, 1'b1}, ack); rd_byte(1'b0, d); rd_byte(1'b1, d2); i2c_stop();
    chk("R4 first read byte", d, 8'h27);
    chk("R4 repeated read byte", d2, 8'h27);

    // R8 force with new register; R7 bit5 independent of route
    frc_n = 1'b0;
    @(negedge clk);
    chk("R8 force low", opull, 6'h3F);
    frc_n = 1'b1; route = 1'b0; ext = 5'b00000;
    @(negedge clk);
    chk("R7 bit5 with pins routed", opull, 6'b011111);

    // R1 reset restores retained value
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
    reg_read(d, ack);
    chk("R1 value after reset", d, 8'h2A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule